// File: doc/BRIEF.md
# Start-Stop Cycle Profiling Counter

This block measures how many clock cycles pass between a start event and a stop event, for profiling stretches of code. A start pulse arms the counter and every following clock edge adds one. The stop pulse closes the interval: the interval value is captured into a readable register, a one-cycle interrupt pulse is raised, and the live readout drops back to zero. Software can collect each interval from the captured register when it takes the interrupt. Minimum and average statistics are computed by software from those values.

Two counting modes exist. With the cumulative bit low, each start begins a fresh interval, and the block keeps the largest interval seen so far in a maximum register. With the cumulative bit high, the count is not cleared at start, so successive intervals add into one running total. Software zeroes that total with a clear strobe, and the maximum register is left untouched in this mode. In either mode a count that passes the all-ones value wraps to zero, keeps counting, and sets a sticky overflow flag that only a software clear strobe or reset removes.

Top module: `cycleProfiler`

## Requirements
- R1: An accepted stop that comes N clock edges after the accepted start leaves `lastCount` equal to N (modulo 2^WIDTH, plus any carried total in cumulative mode), and `stopIrq` is high for exactly the one cycle that follows the stop edge.
- R2: While an interval is open, `curCount` equals the number of clock edges since the start edge (plus any carried total). Whenever no interval is open, `curCount` reads 0.
- R3: With `cumulative` low, each stop updates `maxCount` to the new interval only when that interval is strictly larger than the stored value. For example, intervals of 30, 35, 37 and 33 leave 37.
- R4: With `cumulative` high, a start does not clear the count, so the captured value is the sum of all intervals since the last clear. `maxCount` never changes in this mode. A `totalClr` pulse zeroes the carried total.
- R5: When the count advances from all-ones it wraps to 0, counting continues, and `ovfFlag` goes high. This behaviour is the same in both modes.
- R6: `ovfFlag` stays high until an `ovfClr` pulse. If a wrap and `ovfClr` fall on the same edge, the flag stays high.
- R7: A `maxClr` pulse sets `maxCount` to 0.
- R8: Start and stop together while idle are treated as a stop: no interval opens and no interrupt is raised. A stop while idle does nothing. A start while an interval is open is ignored.
- R9: A synchronous active-low reset zeroes `curCount`, `maxCount`, `lastCount` and `ovfFlag`, clears `stopIrq`, and closes any open interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startEv | input | 1 | Start event pulse |
| stopEv | input | 1 | Stop event pulse |
| cumulative | input | 1 | 1 = add intervals into a running total; 0 = fresh interval with maximum tracking |
| totalClr | input | 1 | Strobe that zeroes the carried count |
| ovfClr | input | 1 | Strobe that clears the overflow flag |
| maxClr | input | 1 | Strobe that zeroes the maximum register |
| curCount | output | WIDTH | Live count; 0 when no interval is open |
| maxCount | output | WIDTH | Largest non-cumulative interval seen |
| lastCount | output | WIDTH | Value captured at the most recent accepted stop |
| ovfFlag | output | 1 | Sticky overflow status |
| stopIrq | output | 1 | One-cycle pulse after an accepted stop |

## Verification
Two pairs of events can coincide and both are provoked on purpose. In the first, the counter wraps on the same edge that software pulses `ovfClr`. The bench opens an interval, counts 256 edges on an 8-bit instance, drives the clear on the wrapping edge, and expects the flag to stay set before it clears the flag alone. In the second, start and stop arrive together while idle, and the bench confirms that neither the interrupt, `curCount` nor `lastCount` moves.

// File: rtl/cycleProfilerPkg.sv
package cycleProfilerPkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic zeroCnt;   // force the count to zero
    logic incCnt;    // advance the count by one
    logic capture;   // latch the closing interval
    logic maxChk;    // compare the closing interval against the maximum
    logic live;      // an interval is open
  } profStrobeT;

endpackage

// File: rtl/cycleProfilerCtrl.sv
module cycleProfilerCtrl
  import cycleProfilerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       cumulative,
  input  logic       totalClr,
  output profStrobeT strb,
  output logic       stopIrq
);

  typedef enum logic {ST_IDLE, ST_RUN} stateT;

  stateT state;
  logic  startAcc;
  logic  stopAcc;

  always_comb begin
    // stop wins over start while idle; start ignored while running
    startAcc     = (state == ST_IDLE) && startEv && !stopEv;
    stopAcc      = (state == ST_RUN) && stopEv;
    strb.live    = (state == ST_RUN);
    strb.incCnt  = (state == ST_RUN);
    strb.capture = stopAcc;
    strb.maxChk  = stopAcc && !cumulative;
    strb.zeroCnt = totalClr || (!cumulative && (startAcc || stopAcc));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stopIrq <= 1'b0;
    end else begin
      stopIrq <= stopAcc;
      unique case (state)
        ST_IDLE: if (startAcc) state <= ST_RUN;
        ST_RUN:  if (stopAcc)  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cycleProfilerData.sv
module cycleProfilerData
  import cycleProfilerPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  profStrobeT       strb,
  input  logic             ovfClr,
  input  logic             maxClr,
  output logic [WIDTH-1:0] curCount,
  output logic [WIDTH-1:0] maxCount,
  output logic [WIDTH-1:0] lastCount,
  output logic             ovfFlag
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] cntPlus;
  logic             wrap;
  logic             newMax;

  always_comb begin
    cntPlus = cnt + ONE;
    wrap    = strb.incCnt && (cnt == ALL_ONES);
    // a fresh measurement taken on a clearing edge still lands
    newMax  = strb.maxChk && (maxClr || (cntPlus > maxCount));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      maxCount  <= '0;
      lastCount <= '0;
      ovfFlag   <= 1'b0;
    end else begin
      if (strb.zeroCnt)     cnt <= '0;
      else if (strb.incCnt) cnt <= cntPlus;

      if (strb.capture) lastCount <= cntPlus;

      if (newMax)      maxCount <= cntPlus;
      else if (maxClr) maxCount <= '0;

      // a wrap on the clearing edge keeps the flag set
      if (wrap)        ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;
    end
  end

  assign curCount = strb.live ? cnt : '0;

endmodule

// File: rtl/cycleProfiler.sv
module cycleProfiler
  import cycleProfilerPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startEv,
  input  logic             stopEv,
  input  logic             cumulative,
  input  logic             totalClr,
  input  logic             ovfClr,
  input  logic             maxClr,
  output logic [WIDTH-1:0] curCount,
  output logic [WIDTH-1:0] maxCount,
  output logic [WIDTH-1:0] lastCount,
  output logic             ovfFlag,
  output logic             stopIrq
);

  profStrobeT strb;

  cycleProfilerCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startEv    (startEv),
    .stopEv     (stopEv),
    .cumulative (cumulative),
    .totalClr   (totalClr),
    .strb       (strb),
    .stopIrq    (stopIrq)
  );

  cycleProfilerData #(.WIDTH(WIDTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .ovfClr    (ovfClr),
    .maxClr    (maxClr),
    .curCount  (curCount),
    .maxCount  (maxCount),
    .lastCount (lastCount),
    .ovfFlag   (ovfFlag)
  );

endmodule

// File: rtl/cycleProfilerChk.sv
module cycleProfilerChk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             cumulative,
  input logic             ovfClr,
  input logic             maxClr,
  input logic [WIDTH-1:0] curCount,
  input logic [WIDTH-1:0] maxCount,
  input logic             ovfFlag,
  input logic             stopIrq
);

  // R1: interrupt is a single-cycle pulse
  a_r1_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    stopIrq |=> !stopIrq);

  // R2: live readout is zero once the stop has happened
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    stopIrq |-> (curCount == '0));

  // R3: without a clear the maximum never shrinks
  a_r3_max_monotone: assert property (@(posedge clk) disable iff (!rstN)
    !maxClr |=> (maxCount >= $past(maxCount)));

  // R4: cumulative mode leaves the maximum alone
  a_r4_cum_max_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cumulative && !maxClr) |=> $stable(maxCount));

  // R6: overflow flag is sticky without a clear
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);

endmodule

bind cycleProfiler cycleProfilerChk #(.WIDTH(WIDTH)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cumulative (cumulative),
  .ovfClr     (ovfClr),
  .maxClr     (maxClr),
  .curCount   (curCount),
  .maxCount   (maxCount),
  .ovfFlag    (ovfFlag),
  .stopIrq    (stopIrq)
);

// File: tb/sim_cycleProfiler.sv
`timescale 1ns/1ps
module sim_cycleProfiler;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startEv = 1'b0, stopEv = 1'b0, cumulative = 1'b0;
  logic         totalClr = 1'b0, ovfClr = 1'b0, maxClr = 1'b0;
  logic [W-1:0] curCount, maxCount, lastCount;
  logic         ovfFlag, stopIrq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cycleProfiler #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .cumulative(cumulative), .totalClr(totalClr), .ovfClr(ovfClr),
    .maxClr(maxClr), .curCount(curCount), .maxCount(maxCount),
    .lastCount(lastCount), .ovfFlag(ovfFlag), .stopIrq(stopIrq)
  );

  typedef struct packed {
    logic        cum;
    logic [15:0] len;
    logic [7:0]  expLast;
    logic [7:0]  expMax;
  } vecT;

  // R3 sequence then R4 accumulation then a fresh R3 interval
  localparam vecT VECS [0:7] = '{
    '{1'b0, 16'd30, 8'd30, 8'd30},
    '{1'b0, 16'd35, 8'd35, 8'd35},
    '{1'b0, 16'd37, 8'd37, 8'd37},
    '{1'b0, 16'd33, 8'd33, 8'd37},
    '{1'b1, 16'd10, 8'd10, 8'd37},
    '{1'b1, 16'd20, 8'd30, 8'd37},
    '{1'b1, 16'd5,  8'd35, 8'd37},
    '{1'b0, 16'd40, 8'd40, 8'd40}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // start on one edge, stop len edges later; returns after the stop edge
  task automatic runInterval(input int len);
    startEv = 1'b1;
    @(negedge clk);
    startEv = 1'b0;
    repeat (len - 1) @(negedge clk);
    stopEv = 1'b1;
    @(negedge clk);
    stopEv = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9 reset state
    check("R9 curCount", curCount, 0);
    check("R9 maxCount", maxCount, 0);
    check("R9 lastCount", lastCount, 0);
    check("R9 ovfFlag", ovfFlag, 0);
    check("R9 stopIrq", stopIrq, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      cumulative = VECS[i].cum;
      @(negedge clk);
      runInterval(int'(VECS[i].len));
      check("R1 irq pulse", stopIrq, 1);
      check("R1 R4 lastCount", lastCount, VECS[i].expLast);
      check("R3 R4 maxCount", maxCount, VECS[i].expMax);
      check("R2 idle readout", curCount, 0);
      @(negedge clk);
      check("R1 irq low", stopIrq, 0);
    end

    // R2 live readout
    startEv = 1'b1;
    @(negedge clk);
    startEv = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 live count", curCount, 5);
    // R8 extra start ignored
    startEv = 1'b1;
    @(negedge clk);
    startEv = 1'b0;
    repeat (5) @(negedge clk);
    stopEv = 1'b1;
    @(negedge clk);
    stopEv = 1'b0;
    check("R8 start while running", lastCount, 12);

    // R8 start and stop together while idle
    @(negedge clk);
    startEv = 1'b1;
    stopEv  = 1'b1;
    @(negedge clk);
    startEv = 1'b0;
    stopEv  = 1'b0;
    check("R8 coincident irq", stopIrq, 0);
    @(negedge clk);
    check("R8 coincident curCount", curCount, 0);
    check("R8 coincident lastCount", lastCount, 12);
    // R8 lone stop while idle
    stopEv = 1'b1;
    @(negedge clk);
    stopEv = 1'b0;
    check("R8 idle stop irq", stopIrq, 0);
    check("R8 idle stop lastCount", lastCount, 12);

    // R5 overflow in fresh mode: 270 wraps to 14
    check("R5 flag clear before", ovfFlag, 0);
    runInterval(270);
    check("R5 wrapped interval", lastCount, 14);
    check("R5 flag set", ovfFlag, 1);
    check("R3 max kept", maxCount, 40);
    @(negedge clk);
    check("R6 flag sticky", ovfFlag, 1);
    ovfClr = 1'b1;
    @(negedge clk);
    ovfClr = 1'b0;
    check("R6 clear", ovfFlag, 0);

    // R6 wrap on the clearing edge
    startEv = 1'b1;
    @(negedge clk);
    startEv = 1'b0;
    repeat (255) @(negedge clk);
    ovfClr = 1'b1;
    @(negedge clk);
    ovfClr = 1'b0;
    check("R6 wrap beats clear", ovfFlag, 1);
    check("R5 counts on after wrap", curCount, 0);
    stopEv = 1'b1;
    @(negedge clk);
    stopEv = 1'b0;
    check("R5 interval after wrap", lastCount, 1);
    ovfClr = 1'b1;
    @(negedge clk);
    ovfClr = 1'b0;
    check("R6 clear again", ovfFlag, 0);

    // R5 overflow in cumulative mode, R4 total clear
    cumulative = 1'b1;
    totalClr = 1'b1;
    @(negedge clk);
    totalClr = 1'b0;
    runInterval(250);
    check("R4 cum total", lastCount, 250);
    check("R5 no wrap yet", ovfFlag, 0);
    @(negedge clk);
    runInterval(10);
    check("R5 cum wrap total", lastCount, 4);
    check("R5 cum flag", ovfFlag, 1);
    check("R4 cum max held", maxCount, 40);
    totalClr = 1'b1;
    @(negedge clk);
    totalClr = 1'b0;
    runInterval(7);
    check("R4 totalClr", lastCount, 7);
    cumulative = 1'b0;

    // R7 maximum clear
    maxClr = 1'b1;
    @(negedge clk);
    maxClr = 1'b0;
    check("R7 maxClr", maxCount, 0);
    runInterval(9);
    check("R3 after clear", maxCount, 9);

    // R9 reset during an open interval
    startEv = 1'b1;
    @(negedge clk);
    startEv = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R9 mid-run curCount", curCount, 0);
    check("R9 mid-run maxCount", maxCount, 0);
    check("R9 mid-run lastCount", lastCount, 0);
    check("R9 mid-run ovfFlag", ovfFlag, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 interval closed", curCount, 0);

    finishRun();
  end

endmodule